// File: doc/BRIEF.md
# Shared External Bus Arbiter with DMA Urgency Detection

This block decides which of four requester classes owns the shared external memory bus: an atomic (locked) core access, the DMA engine, a cache-line fill and an ordinary core access. DMA traffic comes in two directions, memory read and memory write, each with its own request line. When the bus is idle the arbiter picks one requester through a fixed priority ladder. It then holds that grant until the memory side pulses `xfer_done`, so a multi-beat fill, a burst or a locked sequence is never split.

DMA normally sits at the bottom of the ladder. It moves above the cache-line fill and the plain core access when it is urgent. Urgency is derived from the per-channel FIFO state. A transmit channel is urgent when its FIFO is empty and its peripheral is asking for data. A receive channel is urgent when its FIFO is full and its peripheral is presenting another sample. A configuration input can force urgency on at all times. A programmable run limit groups DMA transfers of the same direction, which saves bus turnarounds.

The interface is plain request/grant and carries no data path, so there is no valid/ready handshake. A requester keeps its request asserted until it sees its grant bit. The grant stays asserted until the cycle after `xfer_done`.

Top module: `ebus_arbiter`

## Requirements
- R1: After reset `gnt` is all zero. At every cycle at most one bit of `gnt` is set. The encoding is bit0 locked core, bit1 DMA read, bit2 DMA write, bit3 cache-line fill, bit4 core.
- R2: A locked request wins any arbitration in which it is present.
- R3: When DMA is urgent and any DMA request is pending with no locked request, DMA wins over the fill and core requests.
- R4: With no locked request and no urgent DMA, a fill request wins over core and DMA.
- R5: A core request wins over a non-urgent DMA request.
- R6: A transmit channel (its bit of parameter `RX_MASK` is 0) makes `dma_urgent` high when its `ch_fifo_empty` and `ch_demand` are both high.
- R7: A receive channel (its bit of `RX_MASK` is 1) makes `dma_urgent` high when its `ch_fifo_full` and `ch_demand` are both high. `ch_fifo_empty` has no effect on a receive channel.
- R8: While `force_urgent` is high, `dma_urgent` is high whatever the FIFO state.
- R9: Arbitration happens only while `gnt` is zero, and the chosen grant appears after the next clock edge. A grant holds until a clock edge that sees `xfer_done` high, then `gnt` is zero for at least one cycle. Requests that change during a tenure have no effect on it.
- R10: With `group_limit` N from 1 to 15 and both DMA directions requesting, the direction of the previous DMA grant wins until it has had N consecutive grants. Then the other direction wins. The first DMA grant after reset treats read as the previous direction, with a run of zero.
- R11: With `group_limit` equal to 0 and both DMA directions requesting, DMA read wins.
- R12: `dma_urgent` is combinational: it falls in the same cycle the FIFO or demand condition that raised it is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_req | input | 1 | Locked core access request |
| fill_req | input | 1 | Cache-line fill request |
| core_req | input | 1 | Ordinary core access request |
| dma_req | input | 2 | DMA request, bit0 read, bit1 write |
| xfer_done | input | 1 | Ends the current bus tenure |
| force_urgent | input | 1 | Treat DMA as always urgent |
| group_limit | input | 4 | Same-direction DMA run limit, 0 disables |
| ch_demand | input | NCH | Per-channel peripheral request (tx) or sample delivery (rx) |
| ch_fifo_empty | input | NCH | Per-channel DMA FIFO empty |
| ch_fifo_full | input | NCH | Per-channel DMA FIFO full |
| dma_urgent | output | 1 | DMA urgency flag |
| gnt | output | 5 | One-hot bus grant |

## Verification
Corrupting the idle/busy grant register shows up at the ports within one cycle. A grant would drop without `xfer_done`, persist after it, or change while a transfer is in progress. A wrong direction-run count does not show in single DMA grants. It appears only when both DMA directions are pending: the grant sequence then departs from the expected run pattern at the first turn point, at most `group_limit`+1 grants later. An urgency fault is visible at once on `dma_urgent`. In the following arbitration it also swaps the DMA and fill/core priority.

// File: rtl/ebarb_pkg.sv
package ebarb_pkg;
  localparam int GNT_W  = 5;
  localparam int G_LOCK = 0;
  localparam int G_DRD  = 1;
  localparam int G_DWR  = 2;
  localparam int G_FILL = 3;
  localparam int G_CORE = 4;
  localparam int LIM_W  = 4;
endpackage

// File: rtl/ebarb_urgency.sv
module ebarb_urgency #(
  parameter int NCH = 4,
  parameter logic [NCH-1:0] RX_MASK = '0
) (
  input  logic           force_urgent,
  input  logic [NCH-1:0] ch_demand,
  input  logic [NCH-1:0] ch_fifo_empty,
  input  logic [NCH-1:0] ch_fifo_full,
  output logic           urgent
);
  logic [NCH-1:0] ch_urg;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (RX_MASK[c]) begin : g_rx
      // receive: a sample arrives with no room left
      assign ch_urg[c] = ch_fifo_full[c] & ch_demand[c];
    end else begin : g_tx
      // transmit: peripheral wants data, FIFO has none
      assign ch_urg[c] = ch_fifo_empty[c] & ch_demand[c];
    end
  end

  assign urgent = force_urgent | (|ch_urg);
endmodule

// File: rtl/ebarb_dir_group.sv
module ebarb_dir_group
  import ebarb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       dma_req,
  input  logic [LIM_W-1:0] limit,
  input  logic             take,
  output logic             sel_wr
);
  localparam logic [LIM_W-1:0] RUN_MAX = '1;

  logic             last_wr;
  logic [LIM_W-1:0] run;

  always_comb begin
    if (dma_req == 2'b10)       sel_wr = 1'b1;
    else if (dma_req == 2'b01)  sel_wr = 1'b0;
    else if (limit == '0)       sel_wr = 1'b0;
    else if (run < limit)       sel_wr = last_wr;
    else                        sel_wr = ~last_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_wr <= 1'b0;
      run     <= '0;
    end else if (take) begin
      if (sel_wr == last_wr) begin
        if (run != RUN_MAX) run <= run + 1'b1;
      end else begin
        last_wr <= sel_wr;
        run     <= {{(LIM_W-1){1'b0}}, 1'b1};
      end
    end
  end
endmodule

// File: rtl/ebus_arbiter.sv
module ebus_arbiter
  import ebarb_pkg::*;
#(
  parameter int NCH = 4,
  parameter logic [NCH-1:0] RX_MASK = 4'b1100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_req,
  input  logic             fill_req,
  input  logic             core_req,
  input  logic [1:0]       dma_req,
  input  logic             xfer_done,
  input  logic             force_urgent,
  input  logic [LIM_W-1:0] group_limit,
  input  logic [NCH-1:0]   ch_demand,
  input  logic [NCH-1:0]   ch_fifo_empty,
  input  logic [NCH-1:0]   ch_fifo_full,
  output logic             dma_urgent,
  output logic [GNT_W-1:0] gnt
);
  logic [GNT_W-1:0] gnt_q;
  logic [GNT_W-1:0] pick;
  logic             idle;
  logic             dma_any;
  logic             sel_wr;
  logic             take_dma;
  logic [GNT_W-1:0] dma_onehot;

  ebarb_urgency #(.NCH(NCH), .RX_MASK(RX_MASK)) u_urg (
    .force_urgent (force_urgent),
    .ch_demand    (ch_demand),
    .ch_fifo_empty(ch_fifo_empty),
    .ch_fifo_full (ch_fifo_full),
    .urgent       (dma_urgent)
  );

  ebarb_dir_group u_grp (
    .clk    (clk),
    .rst_n  (rst_n),
    .dma_req(dma_req),
    .limit  (group_limit),
    .take   (take_dma),
    .sel_wr (sel_wr)
  );

  assign idle    = (gnt_q == '0);
  assign dma_any = |dma_req;

  always_comb begin
    dma_onehot = '0;
    dma_onehot[sel_wr ? G_DWR : G_DRD] = 1'b1;
  end

  always_comb begin
    pick = '0;
    if (lock_req)                     pick[G_LOCK] = 1'b1;
    else if (dma_any && dma_urgent)   pick = dma_onehot;
    else if (fill_req)                pick[G_FILL] = 1'b1;
    else if (core_req)                pick[G_CORE] = 1'b1;
    else if (dma_any)                 pick = dma_onehot;
  end

  assign take_dma = idle & (pick[G_DRD] | pick[G_DWR]);

  always_ff @(posedge clk) begin
    if (!rst_n)         gnt_q <= '0;
    else if (idle)      gnt_q <= pick;
    else if (xfer_done) gnt_q <= '0;
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/ebus_arbiter_chk.sv
module ebus_arbiter_chk
  import ebarb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             lock_req,
  input logic             fill_req,
  input logic             core_req,
  input logic [1:0]       dma_req,
  input logic             xfer_done,
  input logic             force_urgent,
  input logic             dma_urgent,
  input logic [GNT_W-1:0] gnt
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && !xfer_done) |=> $stable(gnt));

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && xfer_done) |=> gnt == '0);

  a_r2_lock_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && lock_req) |=> gnt[G_LOCK]);

  a_r3_urgent_dma: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && !lock_req && (|dma_req) && dma_urgent)
      |=> (gnt[G_DRD] || gnt[G_DWR]));

  a_r4_fill_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && !lock_req && !dma_urgent && fill_req) |=> gnt[G_FILL]);

  a_r5_core_over_dma: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && !lock_req && !dma_urgent && !fill_req && core_req)
      |=> gnt[G_CORE]);

  a_r8_force: assert property (@(posedge clk) disable iff (!rst_n)
    force_urgent |-> dma_urgent);
endmodule

bind ebus_arbiter ebus_arbiter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lock_req    (lock_req),
  .fill_req    (fill_req),
  .core_req    (core_req),
  .dma_req     (dma_req),
  .xfer_done   (xfer_done),
  .force_urgent(force_urgent),
  .dma_urgent  (dma_urgent),
  .gnt         (gnt)
);

// File: tb/test_ebus_arbiter.sv
module test_ebus_arbiter;
  localparam int NCH = 4;
  localparam logic [NCH-1:0] RXM = 4'b1100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_req = 0, fill_req = 0, core_req = 0, xfer_done = 0, force_urgent = 0;
  logic [1:0] dma_req = '0;
  logic [3:0] group_limit = '0;
  logic [NCH-1:0] ch_demand = '0, ch_fifo_empty = '0, ch_fifo_full = '0;
  logic dma_urgent;
  logic [4:0] gnt;

  int n_vec = 0;
  int n_bad = 0;

  logic [4:0] exp_g = '0;
  logic       m_last_wr = 1'b0;
  logic [3:0] m_run = '0;

  always #2.5 clk = ~clk;

  ebus_arbiter #(.NCH(NCH), .RX_MASK(RXM)) i_ebus_arbiter (
    .clk(clk), .rst_n(rst_n), .lock_req(lock_req), .fill_req(fill_req),
    .core_req(core_req), .dma_req(dma_req), .xfer_done(xfer_done),
    .force_urgent(force_urgent), .group_limit(group_limit),
    .ch_demand(ch_demand), .ch_fifo_empty(ch_fifo_empty),
    .ch_fifo_full(ch_fifo_full), .dma_urgent(dma_urgent), .gnt(gnt)
  );

  function automatic logic model_urgent();
    logic u = force_urgent;
    for (int c = 0; c < NCH; c++) begin
      if (RXM[c]) u |= ch_fifo_full[c] & ch_demand[c];
      else        u |= ch_fifo_empty[c] & ch_demand[c];
    end
    return u;
  endfunction

  function automatic logic model_sel_wr();
    if (dma_req == 2'b10) return 1'b1;
    if (dma_req == 2'b01) return 1'b0;
    if (group_limit == 0) return 1'b0;
    if (m_run < group_limit) return m_last_wr;
    return ~m_last_wr;
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // call at a negedge after driving inputs
  task automatic tick(input string tag);
    logic [4:0] p;
    logic w;
    #1;
    chk({tag, " urgency"}, {4'b0, dma_urgent}, {4'b0, model_urgent()});
    if (exp_g == '0) begin
      p = '0;
      w = model_sel_wr();
      if (lock_req)                       p[0] = 1;
      else if ((|dma_req) && model_urgent()) p[w ? 2 : 1] = 1;
      else if (fill_req)                  p[3] = 1;
      else if (core_req)                  p[4] = 1;
      else if (|dma_req)                  p[w ? 2 : 1] = 1;
      if (p[1] | p[2]) begin
        if (w == m_last_wr) begin
          if (m_run != 4'hF) m_run++;
        end else begin
          m_last_wr = w;
          m_run = 4'd1;
        end
      end
      exp_g = p;
    end else if (xfer_done) begin
      exp_g = '0;
    end
    @(negedge clk);
    chk(tag, gnt, exp_g);
  endtask

  task automatic clr();
    lock_req = 0; fill_req = 0; core_req = 0; dma_req = '0; xfer_done = 0;
    force_urgent = 0; ch_demand = '0; ch_fifo_empty = '0; ch_fifo_full = '0;
  endtask

  // finish any tenure and leave the bus idle
  task automatic drain();
    clr();
    xfer_done = 1;
    tick("R9");
    tick("R9");
    xfer_done = 0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    chk("R1 reset", gnt, 5'b0);
    rst_n = 1;

    // R2 locked beats everything, then R9 hold without done
    lock_req = 1; fill_req = 1; core_req = 1; dma_req = 2'b11;
    force_urgent = 1;
    tick("R2");
    clr();
    fill_req = 1;
    tick("R9"); tick("R9"); tick("R9");
    drain();

    // R4 fill over core and non-urgent DMA
    fill_req = 1; core_req = 1; dma_req = 2'b01;
    tick("R4"); drain();

    // R5 core over non-urgent DMA
    core_req = 1; dma_req = 2'b10;
    tick("R5"); drain();

    // R3/R6 tx channel 0 empty with demand: urgent DMA beats fill
    fill_req = 1; core_req = 1; dma_req = 2'b01;
    ch_fifo_empty[0] = 1; ch_demand[0] = 1;
    tick("R3 R6"); drain();

    // R7 rx channel 2: full+demand urgent, empty+demand not
    ch_fifo_full[2] = 1; ch_demand[2] = 1; fill_req = 1; dma_req = 2'b10;
    tick("R7"); drain();
    ch_fifo_empty[2] = 1; ch_demand[2] = 1; fill_req = 1; dma_req = 2'b10;
    tick("R7 empty ignored"); drain();
    // tx channel 1 full with demand is not urgent
    ch_fifo_full[1] = 1; ch_demand[1] = 1; core_req = 1; dma_req = 2'b01;
    tick("R6 full tx"); drain();

    // R8 force
    force_urgent = 1; core_req = 1; dma_req = 2'b01;
    tick("R8"); drain();

    // R12 urgency falls when demand goes away
    ch_fifo_empty[1] = 1; ch_demand[1] = 1;
    tick("R12 raise");
    ch_demand[1] = 0;
    tick("R12 clear");
    drain();

    // R10 grouping limit 2: both directions pending continuously
    group_limit = 4'd2;
    for (int k = 0; k < 8; k++) begin
      dma_req = 2'b11; xfer_done = 0;
      tick("R10");
      xfer_done = 1;
      tick("R10");
    end
    drain();

    // R11 limit 0: read always
    group_limit = 4'd0;
    for (int k = 0; k < 4; k++) begin
      dma_req = 2'b11; xfer_done = 0;
      tick("R11");
      xfer_done = 1;
      tick("R11");
    end
    drain();

    // constrained random mix
    for (int k = 0; k < 4000; k++) begin
      lock_req      = ($urandom_range(0, 15) == 0);
      fill_req      = $urandom_range(0, 1);
      core_req      = $urandom_range(0, 1);
      dma_req       = 2'($urandom_range(0, 3));
      xfer_done     = ($urandom_range(0, 2) == 0);
      force_urgent  = ($urandom_range(0, 19) == 0);
      ch_demand     = 4'($urandom);
      ch_fifo_empty = 4'($urandom) & 4'($urandom);
      ch_fifo_full  = 4'($urandom) & 4'($urandom);
      if (k % 500 == 0) group_limit = 4'($urandom_range(0, 15));
      tick("R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule